// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block is the register front end of a 256-entry colour lookup table. Software sees a 16-byte window that takes only full 32-bit accesses. One register holds the table index that will be written next. A second register takes colour components in a fixed rotation of red, then green, then blue. The payload of each component sits in the most significant byte of the written word. After the blue component, the index steps to the next entry, so software can stream whole runs of colours without rewriting the index.

The block does not hold the table itself. It drives a write port with one enable per colour array and a shared index and data byte. It also drives a refresh strobe that names the one entry that changed, so downstream colour conversion can rebuild only that entry. After reset the block sweeps the whole table on its own, one entry per cycle. The sweep writes black everywhere except the last entry, which it writes white. The current index and the pending component are brought out so that the device state can be saved.

Top module: `clut_loader`

## Requirements
- R1: An accepted write to the index register (byte offset 0x0) loads the current index from bits 31:24 of the written word and returns the pending component to red.
- R2: Accepted writes to the colour register (byte offset 0x4) write red, then green, then blue from bits 31:24. Each one raises exactly one bit of `pal_we`: bit 0 for red, bit 1 for green, bit 2 for blue.
- R3: Once the blue component has been written, the current index increases by one, wrapping from 255 to 0, and the pending component goes back to red.
- R4: Every table write appears on the port registered, one cycle after the access is sampled, at the current index. Alongside it comes a single-cycle refresh strobe naming that same index.
- R5: An access counts only when it is a write with all four byte enables set to offset 0x0 or 0x4. Offsets 0x8 and 0xC, offsets not aligned to a word, and partial byte enables produce no table write and no change of state.
- R6: Reads anywhere in the window return zero and change nothing.
- R7: After reset, `init_busy` stays high while the block writes all three arrays of each entry in ascending order, one entry per cycle for 256 cycles. Each entry gets 0, except entry 255, which gets 255. Every entry is refreshed, and bus writes during the sweep are dropped.
- R8: `st_index` shows the current index and `st_phase` the pending component, encoded 0 for red, 1 for green and 2 for blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| pal_we | output | 3 | Array write enables (bit 0 red, 1 green, 2 blue) |
| pal_idx | output | 8 | Table entry being written |
| pal_data | output | 8 | Component value written |
| refresh_valid | output | 1 | One entry changed this cycle |
| refresh_idx | output | 8 | Entry that changed |
| init_busy | output | 1 | Reset sweep in progress |
| st_index | output | 8 | Current index, for state save |
| st_phase | output | 2 | Pending component, for state save |

## Verification
The bench goes after the rotation boundary. It writes blue at index 255, where a design that wraps wrongly would move to 256, drop to 0 too early or leave the phase at green. It also issues an index write in the middle of a triple: a design that does not reset the phase would put the next value into the wrong array. Writes during the reset sweep, partial byte enables and accesses to offsets 0x8, 0xC and 0x6 are each followed by colour writes. A design that accepted any of them would show a shifted index or phase on the next table write. At the end the bench compares a table rebuilt from the write port against its own model, which catches a sweep that leaves entry 255 black or skips an entry.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int IDX_W   = 8;
    localparam int COMP_W  = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int NCOMP   = 3;
    localparam int ENTRIES = 1 << IDX_W;

    localparam logic [ADDR_W-1:0] OFF_INDEX = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_COLOR = 4'h4;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_INDEX = 2'd1,
        ACC_COLOR = 2'd2
    } acc_t;

    typedef struct packed {
        logic [NCOMP-1:0]  we;
        logic [IDX_W-1:0]  idx;
        logic [COMP_W-1:0] data;
    } pal_wr_t;

    function automatic logic [NCOMP-1:0] phase_mask(phase_t ph);
        logic [NCOMP-1:0] m;
        m = '0;
        for (int i = 0; i < NCOMP; i++)
            if (ph == phase_t'(i)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic phase_t phase_next(phase_t ph);
        return (ph == PH_BLU) ? PH_RED : phase_t'(ph + 2'd1);
    endfunction
endpackage

// File: rtl/clut_decode.sv
module clut_decode
    import clut_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    be,
    input  logic          busy,
    output acc_t          kind
);
    logic full_word;
    logic aligned;

    always_comb begin
        full_word = valid && write && (be == 4'b1111) && !busy;
        aligned   = (addr[1:0] == 2'b00);
        kind      = ACC_NONE;
        if (full_word && aligned) begin
            if (addr == OFF_INDEX)      kind = ACC_INDEX;
            else if (addr == OFF_COLOR) kind = ACC_COLOR;
        end
    end
endmodule

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_t          kind,
    input  logic [IW-1:0] new_idx,
    output logic [IW-1:0] cur_idx,
    output phase_t        cur_phase,
    output logic [NCOMP-1:0] wr_mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx   <= '0;
            cur_phase <= PH_RED;
        end else begin
            case (kind)
                ACC_INDEX: begin
                    cur_idx   <= new_idx;
                    cur_phase <= PH_RED;
                end
                ACC_COLOR: begin
                    cur_phase <= phase_next(cur_phase);
                    if (cur_phase == PH_BLU) cur_idx <= cur_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb wr_mask = (kind == ACC_COLOR) ? phase_mask(cur_phase) : '0;
endmodule

// File: rtl/clut_init.sv
module clut_init
    import clut_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    output logic          busy,
    output logic [IW-1:0] sweep_idx,
    output logic          sweep_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b1;
            sweep_idx <= '0;
        end else if (busy) begin
            sweep_idx <= sweep_idx + 1'b1;
            if (sweep_last) busy <= 1'b0;
        end
    end

    always_comb sweep_last = (sweep_idx == {IW{1'b1}});
endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCOMP-1:0]  pal_we,
    output logic [IDX_W-1:0]  pal_idx,
    output logic [COMP_W-1:0] pal_data,
    output logic              refresh_valid,
    output logic [IDX_W-1:0]  refresh_idx,
    output logic              init_busy,
    output logic [IDX_W-1:0]  st_index,
    output logic [1:0]        st_phase
);
    acc_t              kind;
    logic [IDX_W-1:0]  cur_idx;
    phase_t            cur_phase;
    logic [NCOMP-1:0]  wr_mask;
    logic              busy;
    logic [IDX_W-1:0]  sweep_idx;
    logic              sweep_last;
    logic [COMP_W-1:0] top_byte;
    pal_wr_t           wr_next;
    pal_wr_t           wr_q;
    logic              ref_q;
    logic [IDX_W-1:0]  ref_idx_q;

    assign top_byte = bus_wdata[DATA_W-1 -: COMP_W];

    clut_decode #(.AW(ADDR_W)) u_dec (
        .valid(bus_valid), .write(bus_write), .addr(bus_addr),
        .be(bus_be), .busy(busy), .kind(kind)
    );

    clut_seq #(.IW(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .kind(kind), .new_idx(top_byte[IDX_W-1:0]),
        .cur_idx(cur_idx), .cur_phase(cur_phase), .wr_mask(wr_mask)
    );

    clut_init #(.IW(IDX_W)) u_init (
        .clk(clk), .rst(rst), .busy(busy),
        .sweep_idx(sweep_idx), .sweep_last(sweep_last)
    );

    always_comb begin
        if (busy) begin
            wr_next.we   = {NCOMP{1'b1}};
            wr_next.idx  = sweep_idx;
            wr_next.data = sweep_last ? {COMP_W{1'b1}} : '0;
        end else begin
            wr_next.we   = wr_mask;
            wr_next.idx  = cur_idx;
            wr_next.data = top_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q      <= '0;
            ref_q     <= 1'b0;
            ref_idx_q <= '0;
        end else begin
            wr_q      <= wr_next;
            ref_q     <= |wr_next.we;
            ref_idx_q <= wr_next.idx;
        end
    end

    assign bus_rdata     = '0;
    assign pal_we        = wr_q.we;
    assign pal_idx       = wr_q.idx;
    assign pal_data      = wr_q.data;
    assign refresh_valid = ref_q;
    assign refresh_idx   = ref_idx_q;
    assign init_busy     = busy;
    assign st_index      = cur_idx;
    assign st_phase      = cur_phase;
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk
    import clut_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NCOMP-1:0]  pal_we,
    input logic [IDX_W-1:0]  pal_idx,
    input logic              refresh_valid,
    input logic [IDX_W-1:0]  refresh_idx,
    input logic              init_busy,
    input logic [IDX_W-1:0]  st_index,
    input logic [1:0]        st_phase
);
    logic idx_wr;
    logic bad_wr;
    assign idx_wr = bus_valid && bus_write && bus_be == 4'b1111 &&
                    bus_addr == OFF_INDEX && !init_busy;
    assign bad_wr = bus_valid && bus_write && !init_busy &&
                    (bus_be != 4'b1111 || bus_addr[3] || bus_addr[1:0] != 2'b00);

    p_index_load_r1: assert property (@(posedge clk) disable iff (rst)
        $past(idx_wr) |-> (st_phase == PH_RED && st_index == $past(bus_wdata[31:24])));

    p_single_comp_r2: assert property (@(posedge clk) disable iff (rst)
        (pal_we != 3'b111) |-> $onehot0(pal_we));

    p_blue_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(st_phase) == PH_BLU && pal_we == 3'b100) |->
            (st_index == IDX_W'(pal_idx + 1'b1) && st_phase == PH_RED));

    p_refresh_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (pal_we != '0) |-> (refresh_valid && refresh_idx == pal_idx));

    p_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        $past(bad_wr) |-> (pal_we == '0 && $stable(st_index) && $stable(st_phase)));

    p_sweep_hold_r7: assert property (@(posedge clk) disable iff (rst)
        $past(init_busy) |-> ($stable(st_index) && $stable(st_phase)));
endmodule

bind clut_loader clut_loader_chk u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .pal_we(pal_we), .pal_idx(pal_idx), .refresh_valid(refresh_valid),
    .refresh_idx(refresh_idx), .init_busy(init_busy),
    .st_index(st_index), .st_phase(st_phase)
);

// File: tb/clut_loader_tb.sv
`timescale 1ns/1ps
module clut_loader_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  pal_we;
    logic [7:0]  pal_idx;
    logic [7:0]  pal_data;
    logic        refresh_valid;
    logic [7:0]  refresh_idx;
    logic        init_busy;
    logic [7:0]  st_index;
    logic [1:0]  st_phase;

    always #4 clk = ~clk;

    clut_loader u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pal_we(pal_we), .pal_idx(pal_idx),
        .pal_data(pal_data), .refresh_valid(refresh_valid),
        .refresh_idx(refresh_idx), .init_busy(init_busy),
        .st_index(st_index), .st_phase(st_phase)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_idx, m_ph, m_cnt;
    bit m_busy;
    int e_we, e_idx, e_dat;
    int m_r[256], m_g[256], m_b[256];
    int o_r[256], o_g[256], o_b[256];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        e_we = 0;
        if (rst) begin
            m_busy = 1; m_cnt = 0; m_idx = 0; m_ph = 0; e_idx = 0; e_dat = 0;
        end else if (m_busy) begin
            e_we = 7; e_idx = m_cnt; e_dat = (m_cnt == 255) ? 255 : 0;
            m_r[m_cnt] = e_dat; m_g[m_cnt] = e_dat; m_b[m_cnt] = e_dat;
            m_cnt++;
            if (m_cnt == 256) m_busy = 0;
        end else if (bus_valid && bus_write && bus_be == 4'hF && bus_addr[1:0] == 0) begin
            if (bus_addr == 4'h0) begin
                m_idx = bus_wdata[31:24]; m_ph = 0;
            end else if (bus_addr == 4'h4) begin
                e_we = 1 << m_ph; e_idx = m_idx; e_dat = bus_wdata[31:24];
                if (m_ph == 0) m_r[m_idx] = e_dat;
                else if (m_ph == 1) m_g[m_idx] = e_dat;
                else m_b[m_idx] = e_dat;
                if (m_ph == 2) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
                else m_ph++;
            end
        end
    endtask

    task automatic compare();
        if (pal_we[0]) o_r[pal_idx] = pal_data;
        if (pal_we[1]) o_g[pal_idx] = pal_data;
        if (pal_we[2]) o_b[pal_idx] = pal_data;
        chk(pal_we == e_we[2:0], e_we == 7 ? "R7" : "R2", "pal_we", pal_we, e_we);
        chk(refresh_valid == (e_we != 0), "R4", "refresh_valid", refresh_valid, e_we != 0);
        if (e_we != 0) begin
            chk(pal_idx == e_idx[7:0], "R4", "pal_idx", pal_idx, e_idx);
            chk(refresh_idx == e_idx[7:0], "R4", "refresh_idx", refresh_idx, e_idx);
            chk(pal_data == e_dat[7:0], "R2", "pal_data", pal_data, e_dat);
        end
        chk(st_index == m_idx[7:0], "R8", "st_index", st_index, m_idx);
        chk(st_phase == m_ph[1:0], "R8", "st_phase", st_phase, m_ph);
        chk(init_busy == m_busy, "R7", "init_busy", init_busy, m_busy);
        chk(bus_rdata == 0, "R6", "bus_rdata", bus_rdata, 0);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic acc(bit wr, logic [3:0] a, logic [3:0] be, logic [7:0] top);
        bus_valid = 1; bus_write = wr; bus_addr = a; bus_be = be;
        bus_wdata = {top, 8'h5A, 8'hC3, 8'h11};
        step();
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_r[i] = -1; m_g[i] = -1; m_b[i] = -1;
            o_r[i] = -2; o_g[i] = -2; o_b[i] = -2;
        end
        idle(3);                         // reset held: R7 reset state
        rst = 0;
        // R7: writes during the sweep are dropped
        acc(1, 4'h0, 4'hF, 8'd77);
        acc(1, 4'h4, 4'hF, 8'd99);
        while (init_busy) step();
        idle(2);
        // R1/R2/R4: a triple at index 10
        acc(1, 4'h0, 4'hF, 8'd10);
        acc(1, 4'h4, 4'hF, 8'h12);
        acc(1, 4'h4, 4'hF, 8'h34);
        acc(1, 4'h4, 4'hF, 8'h56);
        // R3: auto-increment to 11, back-to-back
        acc(1, 4'h4, 4'hF, 8'hA1);
        acc(1, 4'h4, 4'hF, 8'hA2);
        acc(1, 4'h4, 4'hF, 8'hA3);
        // R3: wrap 255 -> 0
        acc(1, 4'h0, 4'hF, 8'd254);
        for (int i = 0; i < 9; i++) acc(1, 4'h4, 4'hF, 8'(i * 17 + 3));
        // R1: index write mid-triple resets phase
        acc(1, 4'h4, 4'hF, 8'hEE);
        acc(1, 4'h0, 4'hF, 8'd40);
        acc(1, 4'h4, 4'hF, 8'h0F);
        // R5: ignored accesses
        acc(1, 4'h4, 4'h7, 8'hBB);
        acc(1, 4'h4, 4'h8, 8'hBB);
        acc(1, 4'h8, 4'hF, 8'hBB);
        acc(1, 4'hC, 4'hF, 8'hBB);
        acc(1, 4'h6, 4'hF, 8'hBB);
        acc(1, 4'h1, 4'hF, 8'hBB);
        acc(1, 4'h4, 4'hF, 8'h1E);
        // R6: reads change nothing
        acc(0, 4'h0, 4'hF, 8'd3);
        acc(0, 4'h4, 4'hF, 8'd3);
        acc(0, 4'h8, 4'hF, 8'd3);
        acc(1, 4'h4, 4'hF, 8'h2D);
        idle(2);
        // R7 and R2: final table against model
        for (int i = 0; i < 256; i++) begin
            chk(o_r[i] == m_r[i], "R7", $sformatf("red[%0d]", i), o_r[i], m_r[i]);
            chk(o_g[i] == m_g[i], "R7", $sformatf("green[%0d]", i), o_g[i], m_g[i]);
            chk(o_b[i] == m_b[i], "R7", $sformatf("blue[%0d]", i), o_b[i], m_b[i]);
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule